// File: doc/BRIEF.md
# Self-Timed Program Cycle Sequencer

This block carries out the timed programming operations of a small word-organised nonvolatile memory model. A serial command decoder upstream hands it one command per strobe: an opcode, a word address and a data word. The sequencer keeps a software enable latch and honours a hardware program-enable input. It runs a cycle timer clocked by a prescaled tick, then updates the memory array through a simple write port. It drives a busy flag for the whole operation.

Four programming operations exist: erase of one word, write of one word, erase of the whole array, and write of the whole array. Whole-array writing always runs an erase pass over every location first and then a data pass. Each operation waits its own number of ticks before its array update. The timing parameters are given in ticks, so the scale can shrink for simulation.

States: `ST_IDLE` (accepting strobes), `ST_WAIT` (timer running for the current pass) and `ST_SWEEP` (array update, one location per clock). The transitions are:

- idle→wait on an accepted programming strobe;
- wait→sweep when the timer expires;
- sweep→idle after the last location of the final pass;
- sweep→wait between the erase pass and the data pass of a whole-array write.

Top module: `prog_cycle_seq`

## Requirements
- R1: After reset `busy` and `arr_we` are low and the enable latch is clear.
- R2: While the enable latch is clear, every programming strobe (opcodes 3, 4, 5, 6) is ignored: `busy` stays low and no array write happens.
- R3: Opcode 1 sets the enable latch and opcode 2 clears it. The latch persists across operations until cleared or reset. Opcode 0 (read) and opcode 7 change nothing and start nothing.
- R4: With `prog_en` low at the strobe, no programming operation starts, whatever the latch holds.
- R5: Opcode 3 (word erase) writes all ones to `cmd_addr` only.
- R6: Opcode 4 (word write) stores `cmd_data` at `cmd_addr` only.
- R7: Opcode 5 (array erase) writes all ones to every location, in ascending address order.
- R8: Opcode 6 (array write) first writes all ones to every address in ascending order, then writes `cmd_data` to every address in ascending order.
- R9: `busy` is high from the clock after the strobe until the clock after the last array update. The busy time in clocks is T_WORD×TICK_DIV+1 for opcodes 3 and 4, T_ERASE_ALL×TICK_DIV+DEPTH for opcode 5, and T_WRITE_ALL×TICK_DIV+2×DEPTH for opcode 6.
- R10: A strobe that arrives while `busy` is high is ignored and does not change the running operation.
- R11: Once started, an operation runs to completion even if `prog_en` falls during it.
- R12: `arr_we` is only ever high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | Opcode (0 read, 1 enable, 2 disable, 3 word erase, 4 word write, 5 array erase, 6 array write) |
| cmd_addr | input | ADDR_W | Target word address |
| cmd_data | input | DATA_W | Data word for writes |
| prog_en | input | 1 | Hardware program enable, high allows programming |
| busy | output | 1 | High while an operation runs |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |

## Verification
A strobe is sampled on a rising edge, and `busy` is visible from the next falling edge. The bench therefore counts falling edges with `busy` high and compares that count exactly with the R9 formula. The array is mirrored from the write port on each rising edge, and the mirror is compared with a reference only after `busy` has fallen. Any late or extra write therefore shows up as a miscompare. Ignored strobes (R2, R3, R4, R10) are judged by a zero busy count or an unchanged busy length, together with an unchanged mirror and an unchanged write total.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_WEN    = 3'd1,
        OP_WDS    = 3'd2,
        OP_ERASE  = 3'd3,
        OP_WRITE  = 3'd4,
        OP_ERALL  = 3'd5,
        OP_WRALL  = 3'd6,
        OP_RSVD   = 3'd7
    } prog_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SWEEP = 2'd2
    } seq_state_e;

endpackage

// File: rtl/prog_tick_div.sv
module prog_tick_div #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] pre_q;

    assign tick = !clear && (pre_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clear || pre_q == LAST) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/prog_tick_timer.sv
module prog_tick_timer #(
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    logic [TW-1:0] cnt_q;

    assign expire = tick && (cnt_q == limit - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/prog_cycle_seq.sv
module prog_cycle_seq
    import prog_seq_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int TICK_DIV    = 4,
    parameter int T_WORD      = 5,
    parameter int T_ERASE_ALL = 15,
    parameter int T_WRITE_ALL = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              prog_en,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int TW    = $clog2(T_WRITE_ALL + 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
    localparam logic [TW-1:0] LIM_WORD  = TW'(T_WORD);
    localparam logic [TW-1:0] LIM_ERALL = TW'(T_ERASE_ALL);
    localparam logic [TW-1:0] LIM_WRAL2 = TW'(T_WRITE_ALL - T_ERASE_ALL);

    seq_state_e        state;
    prog_op_e          op_q;
    prog_op_e          cmd_op_e;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              en_q;
    logic              data_pass;
    logic              single_q;
    logic              tmr_clear;
    logic              tick;
    logic              expire;
    logic [TW-1:0]     limit;

    assign cmd_op_e = prog_op_e'(cmd_op);
    assign single_q = (op_q == OP_ERASE) || (op_q == OP_WRITE);

    prog_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tmr_clear),
        .tick  (tick)
    );

    prog_tick_timer #(.TW(TW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (tmr_clear),
        .tick   (tick),
        .limit  (limit),
        .expire (expire)
    );

    // state register and captured command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            op_q      <= OP_READ;
            addr_q    <= '0;
            data_q    <= '0;
            en_q      <= 1'b0;
            data_pass <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        case (cmd_op_e)
                            OP_WEN: en_q <= 1'b1;
                            OP_WDS: en_q <= 1'b0;
                            OP_ERASE, OP_WRITE, OP_ERALL, OP_WRALL: begin
                                if (en_q && prog_en) begin
                                    state     <= ST_WAIT;
                                    op_q      <= cmd_op_e;
                                    data_q    <= cmd_data;
                                    addr_q    <= (cmd_op_e == OP_ERASE || cmd_op_e == OP_WRITE)
                                                 ? cmd_addr : '0;
                                    data_pass <= (cmd_op_e == OP_WRITE);
                                end
                            end
                            default: ;
                        endcase
                    end
                end
                ST_WAIT: begin
                    if (expire) state <= ST_SWEEP;
                end
                ST_SWEEP: begin
                    if (single_q || addr_q == LAST_ADDR) begin
                        if (op_q == OP_WRALL && !data_pass) begin
                            data_pass <= 1'b1;
                            addr_q    <= '0;
                            state     <= ST_WAIT;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        addr_q <= addr_q + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs and timer control
    always_comb begin
        busy      = 1'b0;
        arr_we    = 1'b0;
        tmr_clear = 1'b1;
        arr_addr  = addr_q;
        arr_wdata = data_pass ? data_q : '1;
        unique case (state)
            ST_IDLE:  ;
            ST_WAIT: begin
                busy      = 1'b1;
                tmr_clear = 1'b0;
            end
            ST_SWEEP: begin
                busy   = 1'b1;
                arr_we = 1'b1;
            end
            default: ;
        endcase
        if (single_q)                       limit = LIM_WORD;
        else if (op_q == OP_WRALL && data_pass) limit = LIM_WRAL2;
        else                                limit = LIM_ERALL;
    end
endmodule

// File: rtl/prog_cycle_seq_chk.sv
module prog_cycle_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic arr_we,
    input logic prog_en,
    input logic en_latch
);
    assert_we_only_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    assert_locked_no_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !en_latch) |=> !busy);

    assert_pe_inhibit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !prog_en) |=> !busy);

    assert_wait_before_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !arr_we);

    assert_fall_after_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(arr_we));

    assert_wait_not_cut_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !arr_we) |=> busy);
endmodule

bind prog_cycle_seq prog_cycle_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .arr_we   (arr_we),
    .prog_en  (prog_en),
    .en_latch (en_q)
);

// File: tb/test_prog_cycle_seq.sv
module test_prog_cycle_seq;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int DIV    = 4;
    localparam int TWD    = 5;
    localparam int TEA    = 15;
    localparam int TWA    = 30;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int BW_WORD  = TWD * DIV + 1;
    localparam int BW_ERALL = TEA * DIV + DEPTH;
    localparam int BW_WRALL = TWA * DIV + 2 * DEPTH;

    typedef struct packed {
        logic [2:0] op;
        logic [3:0] addr;
        logic [7:0] data;
        logic       pe;
        logic [7:0] exp_busy;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{3'd4, 4'd3,  8'h5A, 1'b1, 8'd0},                // R2 locked
        '{3'd1, 4'd0,  8'h00, 1'b1, 8'd0},                // R3 enable
        '{3'd4, 4'd3,  8'h5A, 1'b1, 8'(BW_WORD)},         // R6
        '{3'd3, 4'd3,  8'h00, 1'b1, 8'(BW_WORD)},         // R5
        '{3'd4, 4'd7,  8'hC3, 1'b0, 8'd0},                // R4
        '{3'd5, 4'd0,  8'h00, 1'b1, 8'(BW_ERALL)},        // R7
        '{3'd4, 4'd2,  8'h11, 1'b1, 8'(BW_WORD)},         // R6
        '{3'd0, 4'd2,  8'h00, 1'b1, 8'd0},                // R3 read
        '{3'd6, 4'd0,  8'hA5, 1'b1, 8'(BW_WRALL)},        // R8
        '{3'd2, 4'd0,  8'h00, 1'b1, 8'd0},                // R3 disable
        '{3'd3, 4'd4,  8'h00, 1'b1, 8'd0},                // R3 locked again
        '{3'd1, 4'd0,  8'h00, 1'b1, 8'd0},                // R3
        '{3'd4, 4'd15, 8'h7E, 1'b1, 8'(BW_WORD)}          // R6 top address
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = 3'd0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [DATA_W-1:0] cmd_data = '0;
    logic              prog_en = 1'b1;
    logic              busy;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_addr;
    logic [DATA_W-1:0] arr_wdata;

    int n_chk = 0;
    int n_bad = 0;

    logic [DATA_W-1:0] mem     [DEPTH] = '{default: 8'h00};
    logic [DATA_W-1:0] ref_mem [DEPTH] = '{default: 8'h00};
    logic [11:0]       wlog    [64];
    int                wr_total = 0;
    logic              ref_en = 1'b0;

    always #5 clk = ~clk;

    prog_cycle_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TICK_DIV(DIV),
        .T_WORD(TWD), .T_ERASE_ALL(TEA), .T_WRITE_ALL(TWA)
    ) i_prog_cycle_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .prog_en(prog_en),
        .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    always @(posedge clk) begin
        if (arr_we) begin
            mem[arr_addr]         <= arr_wdata;
            wlog[wr_total % 64]   <= {arr_addr, arr_wdata};
            wr_total              <= wr_total + 1;
        end
    end

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int mem_mism();
        int m = 0;
        for (int i = 0; i < DEPTH; i++) if (mem[i] !== ref_mem[i]) m++;
        return m;
    endfunction

    function automatic int ref_apply(input logic [2:0] op, input logic [3:0] a,
                                     input logic [7:0] d, input logic pe);
        if (op == 3'd1) ref_en = 1'b1;
        else if (op == 3'd2) ref_en = 1'b0;
        else if (op >= 3'd3 && op <= 3'd6 && ref_en && pe) begin
            case (op)
                3'd3: begin ref_mem[a] = 8'hFF; return 1; end
                3'd4: begin ref_mem[a] = d; return 1; end
                3'd5: begin for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF; return DEPTH; end
                default: begin for (int i = 0; i < DEPTH; i++) ref_mem[i] = d; return 2 * DEPTH; end
            endcase
        end
        return 0;
    endfunction

    // inj_kind: 0 none, 1 strobe a word write at count inj_at, 2 drop prog_en at inj_at
    task automatic issue(input logic [2:0] op, input logic [3:0] a, input logic [7:0] d,
                         input int inj_kind, input int inj_at, output int n);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 0;
        while (busy && n < 1000) begin
            n++;
            if (inj_kind == 1 && n == inj_at) begin
                cmd_valid = 1'b1; cmd_op = 3'd4; cmd_addr = 4'd1; cmd_data = 8'h99;
            end else begin
                cmd_valid = 1'b0;
            end
            if (inj_kind == 2 && n == inj_at) prog_en = 1'b0;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(10 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n, w0, ew, m;
        repeat (3) @(negedge clk);
        chk(int'(busy), 0, "R1 busy after reset");
        chk(int'(arr_we), 0, "R1 arr_we after reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(int'(busy), 0, "R1 busy after release");

        for (int v = 0; v < NV; v++) begin
            w0 = wr_total;
            prog_en = VEC[v].pe;
            ew = ref_apply(VEC[v].op, VEC[v].addr, VEC[v].data, VEC[v].pe);
            issue(VEC[v].op, VEC[v].addr, VEC[v].data, 0, 0, n);
            prog_en = 1'b1;
            chk(n, int'(VEC[v].exp_busy), $sformatf("R9/R2/R3/R4 busy length vec %0d", v));
            chk(wr_total - w0, ew, $sformatf("R5/R6/R7/R8 write count vec %0d", v));
            chk(mem_mism(), 0, $sformatf("R5/R6/R7/R8 array contents vec %0d", v));
        end

        // R8 pass ordering, with R10 strobe injected during the run
        w0 = wr_total;
        ew = ref_apply(3'd6, 4'd0, 8'h3C, 1'b1);
        issue(3'd6, 4'd0, 8'h3C, 1, 40, n);
        chk(n, BW_WRALL, "R10 busy length with strobe while busy");
        chk(mem_mism(), 0, "R10 strobe while busy left array untouched");
        chk(wr_total - w0, ew, "R10 write count");
        m = 0;
        for (int k = 0; k < DEPTH; k++) begin
            if (wlog[(w0 + k) % 64] !== {4'(k), 8'hFF}) m++;
            if (wlog[(w0 + DEPTH + k) % 64] !== {4'(k), 8'h3C}) m++;
        end
        chk(m, 0, "R8 erase pass then data pass ascending");
        m = 0;
        for (int k = 0; k < 2 * DEPTH; k++) if (wlog[(w0 + k) % 64][11:8] !== 4'(k % DEPTH)) m++;
        chk(m, 0, "R7 ascending address order");

        // R11 prog_en falling mid-operation
        w0 = wr_total;
        ew = ref_apply(3'd4, 4'd9, 8'h6D, 1'b1);
        issue(3'd4, 4'd9, 8'h6D, 2, 5, n);
        prog_en = 1'b1;
        chk(n, BW_WORD, "R11 busy length after prog_en drop");
        chk(mem_mism(), 0, "R11 word written after prog_en drop");

        // R3 opcode 7 does nothing, latch still set afterwards
        w0 = wr_total;
        issue(3'd7, 4'd5, 8'h42, 0, 0, n);
        chk(n, 0, "R3 reserved opcode starts nothing");
        chk(wr_total - w0, 0, "R3 reserved opcode writes nothing");
        ew = ref_apply(3'd3, 4'd9, 8'h00, 1'b1);
        issue(3'd3, 4'd9, 8'h00, 0, 0, n);
        chk(n, BW_WORD, "R3 latch persists");
        chk(mem_mism(), 0, "R5 erase after reserved opcode");

        // R1 reset clears latch
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        ref_en = 1'b0;
        w0 = wr_total;
        issue(3'd4, 4'd0, 8'h12, 0, 0, n);
        chk(n, 0, "R1 latch cleared by reset");
        chk(wr_total - w0, 0, "R1 no write after reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule